// File: doc/BRIEF.md
# Packed Single-Precision Compare Predicate Unit

This unit compares two 128-bit operand vectors lane by lane. Each vector holds four 32-bit single-precision floating-point values. A 3-bit predicate code selects one test for all four lanes. The tests are equal, not-equal, ordered, unordered, and raw bit-pattern equality. The unit handles NaN operands and the sign of zero the way floating-point comparison rules require, and it does no arithmetic.

Each lane result is either all ones or all zeros. The unit gathers the top bit of each lane into a 4-bit summary. A separate test stage takes two 128-bit mask vectors and reports two flags. The first flag is set when the masks share no set bit. The second is set when every bit set in the second mask is also set in the first. Software-style reflexive equality ("NaN equals NaN") can be built by combining two results: run the equal predicate and the bit-equality predicate, then feed both masks to the test stage.

The unit has no clock and no state. Every output follows its inputs.

Top module: `pcmp_unit`

## Requirements
- R1: Every lane of `lane_mask` is either all 32 bits set (true) or all 32 bits clear (false).
- R2: Predicate code 0 (equal, ordered) is true in a lane only when neither operand is a NaN and either the two bit patterns match or both operands are zeros of any sign, so +0 equals -0.
- R3: Predicate code 1 (not-equal, unordered) is true in a lane exactly where code 0 would be false, so it is true when either operand is a NaN.
- R4: Predicate code 2 (ordered) is true in a lane exactly when neither operand is a NaN. Applied to an operand and itself, it is false only in lanes holding a NaN.
- R5: Predicate code 3 (unordered) is true in a lane exactly when at least one operand is a NaN.
- R6: Predicate code 4 (bit equality) is true when the raw 32-bit patterns match. Identical NaN encodings therefore compare equal, and +0 against -0 compares unequal.
- R7: Predicate codes 5, 6 and 7 drive an all-zero `lane_mask` and an all-zero `lane_bits`.
- R8: A value is a NaN when exponent bits 30:23 are all ones and mantissa bits 22:0 are nonzero. Quiet and signalling NaNs of either sign are treated alike, and an infinity (zero mantissa) is not a NaN.
- R9: `lane_bits[i]` equals bit 31 of lane i of `lane_mask`, where lane i occupies bits 32*i+31 down to 32*i, so lane 0 maps to bit 0.
- R10: `zf` is 1 exactly when `tst_x & tst_y` is all zero.
- R11: `cf` is 1 exactly when `~tst_x & tst_y` is all zero.
- R12: The outputs are combinational in the present inputs. A lane's result depends only on that lane's two operands, and the flags depend only on the two test masks presented at that time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_vec | input | 128 | First operand, four single-precision lanes |
| b_vec | input | 128 | Second operand, four single-precision lanes |
| pred_sel | input | 3 | Predicate code applied to every lane |
| tst_x | input | 128 | First mask for the flag test |
| tst_y | input | 128 | Second mask for the flag test |
| lane_mask | output | 128 | Per-lane result, all ones or all zeros |
| lane_bits | output | 4 | Top bit of each lane of lane_mask |
| zf | output | 1 | Set when tst_x AND tst_y is zero |
| cf | output | 1 | Set when NOT tst_x AND tst_y is zero |

## Verification
The bench sweeps every predicate code over all pairings of a set of special values in every lane position. The values include signed zeros, infinities, quiet and signalling NaNs with different payloads, denormals and the largest finite number.

This sweep targets several specific errors:
- A design that tested only the exponent for NaN would call infinities unordered.
- A design that compared bit patterns alone would report +0 and -0 as unequal under the equal predicate.
- A design that wrote the not-equal predicate in ordered form would miss NaN lanes.
- A design with swapped lanes would fail because each lane carries a different pair.

The flag stage is driven with disjoint masks, identical masks, complementary masks, an empty second mask and pseudo-random masks. An inverted operand in the AND-NOT term, or a swap of the two flags, shows up as a wrong flag on at least one of these.

// File: rtl/pcmp_pkg.sv
package pcmp_pkg;

  typedef enum logic [2:0] {
    PRED_EQ_ORD    = 3'd0,
    PRED_NEQ_UNORD = 3'd1,
    PRED_ORD       = 3'd2,
    PRED_UNORD     = 3'd3,
    PRED_BITEQ     = 3'd4
  } pred_e;

  typedef struct packed {
    logic is_nan;
    logic is_zero;
  } fclass_t;

endpackage

// File: rtl/pcmp_classify.sv
module pcmp_classify #(
  parameter int LANE_W = 32,
  parameter int EXP_W  = 8
) (
  input  logic [LANE_W-1:0]  val,
  output pcmp_pkg::fclass_t  cls
);
  localparam int MAN_W = LANE_W - 1 - EXP_W;

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;

  assign exp_f = val[LANE_W-2 -: EXP_W];
  assign man_f = val[MAN_W-1:0];

  always_comb begin
    cls.is_nan  = (&exp_f) && (|man_f);
    cls.is_zero = ~|val[LANE_W-2:0];
  end
endmodule

// File: rtl/pcmp_lane.sv
module pcmp_lane #(
  parameter int LANE_W = 32,
  parameter int EXP_W  = 8
) (
  input  logic [LANE_W-1:0] a_lane,
  input  logic [LANE_W-1:0] b_lane,
  input  logic [2:0]        sel,
  output logic [LANE_W-1:0] res
);
  import pcmp_pkg::*;

  fclass_t a_cls, b_cls;
  logic    any_nan, same_bits, both_zero, eq_ord, hit;

  pcmp_classify #(.LANE_W(LANE_W), .EXP_W(EXP_W)) u_cls_a (.val(a_lane), .cls(a_cls));
  pcmp_classify #(.LANE_W(LANE_W), .EXP_W(EXP_W)) u_cls_b (.val(b_lane), .cls(b_cls));

  always_comb begin
    any_nan   = a_cls.is_nan | b_cls.is_nan;
    same_bits = (a_lane == b_lane);
    both_zero = a_cls.is_zero & b_cls.is_zero;
    eq_ord    = !any_nan && (same_bits || both_zero);
    case (pred_e'(sel))
      PRED_EQ_ORD:    hit = eq_ord;
      PRED_NEQ_UNORD: hit = !eq_ord;
      PRED_ORD:       hit = !any_nan;
      PRED_UNORD:     hit = any_nan;
      PRED_BITEQ:     hit = same_bits;
      default:        hit = 1'b0;
    endcase
    res = {LANE_W{hit}};
  end
endmodule

// File: rtl/pcmp_flag_test.sv
module pcmp_flag_test #(
  parameter int VEC_W = 128
) (
  input  logic [VEC_W-1:0] mx,
  input  logic [VEC_W-1:0] my,
  output logic             zf,
  output logic             cf
);
  logic [VEC_W-1:0] both_set, y_not_x;

  always_comb begin
    both_set = mx & my;
    y_not_x  = ~mx & my;
    zf       = ~|both_set;
    cf       = ~|y_not_x;
  end
endmodule

// File: rtl/pcmp_unit.sv
module pcmp_unit #(
  parameter int LANES  = 4,
  parameter int LANE_W = 32,
  parameter int EXP_W  = 8,
  localparam int VEC_W = LANES * LANE_W
) (
  input  logic [VEC_W-1:0] a_vec,
  input  logic [VEC_W-1:0] b_vec,
  input  logic [2:0]       pred_sel,
  input  logic [VEC_W-1:0] tst_x,
  input  logic [VEC_W-1:0] tst_y,
  output logic [VEC_W-1:0] lane_mask,
  output logic [LANES-1:0] lane_bits,
  output logic             zf,
  output logic             cf
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pcmp_lane #(.LANE_W(LANE_W), .EXP_W(EXP_W)) u_lane (
      .a_lane (a_vec[g*LANE_W +: LANE_W]),
      .b_lane (b_vec[g*LANE_W +: LANE_W]),
      .sel    (pred_sel),
      .res    (lane_mask[g*LANE_W +: LANE_W])
    );
    assign lane_bits[g] = lane_mask[g*LANE_W + LANE_W - 1];
  end

  pcmp_flag_test #(.VEC_W(VEC_W)) u_flags (
    .mx (tst_x),
    .my (tst_y),
    .zf (zf),
    .cf (cf)
  );
endmodule

// File: rtl/pcmp_unit_chk.sv
module pcmp_unit_chk #(
  parameter int LANES  = 4,
  parameter int LANE_W = 32,
  localparam int VEC_W = LANES * LANE_W
) (
  input logic [VEC_W-1:0] a_vec,
  input logic [VEC_W-1:0] b_vec,
  input logic [2:0]       pred_sel,
  input logic [VEC_W-1:0] tst_x,
  input logic [VEC_W-1:0] tst_y,
  input logic [VEC_W-1:0] lane_mask,
  input logic [LANES-1:0] lane_bits,
  input logic             zf,
  input logic             cf
);
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      // R1 R9
      lane_uniform_chk: assert (lane_mask[i*LANE_W +: LANE_W] == {LANE_W{lane_bits[i]}})
        else $error("lane %0d not uniform or summary mismatch", i);
      // R6
      biteq_same_chk: assert (!(pred_sel == 3'd4 && a_vec[i*LANE_W +: LANE_W] == b_vec[i*LANE_W +: LANE_W])
                              || lane_bits[i])
        else $error("bit equality missed on lane %0d", i);
      // R3
      neq_diff_chk: assert (!(pred_sel == 3'd1 && a_vec[i*LANE_W +: LANE_W-1] != b_vec[i*LANE_W +: LANE_W-1])
                            || lane_bits[i])
        else $error("not-equal missed differing lane %0d", i);
    end
    // R7
    unused_code_chk: assert (pred_sel <= 3'd4 || lane_bits == '0)
      else $error("unused predicate code produced a set lane");
    // R10 R11
    empty_y_chk: assert (tst_y != '0 || (zf && cf))
      else $error("flags wrong for empty second mask");
    // R10 R11
    same_mask_chk: assert (tst_y == '0 || tst_x != tst_y || (!zf && cf))
      else $error("flags wrong for identical masks");
  end
endmodule

bind pcmp_unit pcmp_unit_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .a_vec(a_vec), .b_vec(b_vec), .pred_sel(pred_sel), .tst_x(tst_x), .tst_y(tst_y),
  .lane_mask(lane_mask), .lane_bits(lane_bits), .zf(zf), .cf(cf)
);

// File: tb/pcmp_unit_tb.sv
module pcmp_unit_tb;
  localparam int NV = 12;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [127:0] a_vec, b_vec, tst_x, tst_y, lane_mask;
  logic [2:0]   pred_sel;
  logic [3:0]   lane_bits;
  logic         zf, cf;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [31:0] vals [NV];
  logic [31:0] rng = 32'h1234_5679;

  pcmp_unit u_dut (
    .a_vec(a_vec), .b_vec(b_vec), .pred_sel(pred_sel), .tst_x(tst_x), .tst_y(tst_y),
    .lane_mask(lane_mask), .lane_bits(lane_bits), .zf(zf), .cf(cf)
  );

  function automatic bit f_nan(logic [31:0] v);
    return (v[30:23] == 8'd255) && (v[22:0] != 23'd0);
  endfunction

  function automatic bit f_lane(logic [2:0] code, logic [31:0] a, logic [31:0] b);
    bit unord = f_nan(a) || f_nan(b);
    bit eq    = !unord && (a == b || (a[30:0] == 0 && b[30:0] == 0));
    case (code)
      3'd0: return eq;
      3'd1: return !eq;
      3'd2: return !unord;
      3'd3: return unord;
      3'd4: return a == b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string code_tag(logic [2:0] code);
    case (code)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic logic [31:0] nxt(logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic flag_case(logic [127:0] x, logic [127:0] y);
    bit ez = 1'b1, ec = 1'b1;
    @(posedge clk);
    tst_x = x; tst_y = y;
    for (int k = 0; k < 128; k++) begin
      if (x[k] && y[k]) ez = 1'b0;
      if (!x[k] && y[k]) ec = 1'b0;
    end
    step();
    check("R10", {127'd0, zf}, {127'd0, ez});
    check("R11", {127'd0, cf}, {127'd0, ec});
  endtask

  initial begin
    vals[0]  = 32'h0000_0000; vals[1]  = 32'h8000_0000;
    vals[2]  = 32'h3F80_0000; vals[3]  = 32'hBF80_0000;
    vals[4]  = 32'h7F80_0000; vals[5]  = 32'hFF80_0000;
    vals[6]  = 32'h7FC0_0000; vals[7]  = 32'h7F80_0001;
    vals[8]  = 32'h7FC0_1234; vals[9]  = 32'hFFC0_0000;
    vals[10] = 32'h0000_0001; vals[11] = 32'h7F7F_FFFF;
    a_vec = '0; b_vec = '0; pred_sel = 3'd0; tst_x = '0; tst_y = '0;
    step();
    // reset-free start: equal zeros under code 0 give all ones (R2), empty masks set both flags (R10)
    check("R2", lane_mask, {128{1'b1}});
    check("R10", {127'd0, zf & cf}, 128'd1);

    for (int c = 0; c < 8; c++) begin
      for (int i = 0; i < NV; i++) begin
        for (int j = 0; j < NV; j++) begin
          logic [127:0] exp_m;
          logic [3:0]   exp_b;
          bit uni;
          @(posedge clk);
          pred_sel = 3'(c);
          for (int k = 0; k < 4; k++) begin
            a_vec[k*32 +: 32] = vals[(i + k) % NV];
            b_vec[k*32 +: 32] = vals[(j + 5*k) % NV];
          end
          for (int k = 0; k < 4; k++) begin
            exp_b[k] = f_lane(3'(c), vals[(i + k) % NV], vals[(j + 5*k) % NV]);
            exp_m[k*32 +: 32] = {32{exp_b[k]}};
          end
          step();
          check(code_tag(3'(c)), lane_mask, exp_m);
          check("R9", {124'd0, lane_bits}, {124'd0, exp_b});
          uni = 1'b1;
          for (int k = 0; k < 4; k++)
            if (lane_mask[k*32 +: 32] != '0 && lane_mask[k*32 +: 32] != '1) uni = 1'b0;
          check("R1", {127'd0, uni}, 128'd1);
        end
      end
    end

    // R8: infinity ordered, signalling NaN unordered, negative NaN unordered
    @(posedge clk);
    pred_sel = 3'd2;
    a_vec = {32'h7F80_0000, 32'hFF80_0000, 32'h7F80_0001, 32'hFFFF_FFFF};
    b_vec = {32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0000};
    step();
    check("R8", {124'd0, lane_bits}, {124'd0, 4'b1100});

    // R12: changing lane 2 only leaves lanes 0,1,3 unchanged
    @(posedge clk);
    pred_sel = 3'd0;
    a_vec = {32'h3F80_0000, 32'h7FC0_0000, 32'h8000_0000, 32'h4000_0000};
    b_vec = {32'h3F80_0000, 32'h4000_0000, 32'h0000_0000, 32'h4000_0000};
    step();
    check("R12", {124'd0, lane_bits}, {124'd0, 4'b1011});
    @(posedge clk);
    a_vec[95:64] = 32'h4000_0000;
    step();
    check("R12", {124'd0, lane_bits}, {124'd0, 4'b1111});

    // R10 R11 directed and pseudo-random masks
    flag_case('0, '0);
    flag_case({128{1'b1}}, '0);
    flag_case({64'hFFFF_0000_FFFF_0000, 64'h0}, {64'h0000_FFFF_0000_FFFF, 64'h0});
    flag_case({4{32'hA5A5_0F0F}}, {4{32'hA5A5_0F0F}});
    flag_case({4{32'hA5A5_0F0F}}, ~{4{32'hA5A5_0F0F}});
    flag_case('0, 128'd1 << 127);
    flag_case({128{1'b1}}, {128{1'b1}});
    for (int n = 0; n < 200; n++) begin
      logic [127:0] x, y;
      for (int k = 0; k < 4; k++) begin rng = nxt(rng); x[k*32 +: 32] = rng; end
      for (int k = 0; k < 4; k++) begin rng = nxt(rng); y[k*32 +: 32] = rng; end
      if (n % 4 == 1) y = y & ~x;
      if (n % 4 == 2) y = y & x;
      flag_case(x, y);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule